// File: doc/BRIEF.md
# Mapped Quad Register Window

This block sits beside a 512-word, 32-bit register file. It holds four hidden 32-bit quad registers. A map command lays them over any four consecutive, four-aligned addresses of the register file. While the window is mapped, core reads of the four covered addresses return the quad registers in place of the RAM words. Core writes to a covered address update both the quad register and the RAM word underneath.

A wide memory read delivers 128 bits on the fill port. On its valid strobe it loads all four quad registers at once and leaves the RAM untouched. Coherence is therefore asymmetric. Once the window moves away, the old addresses show whatever the core last wrote there, and they never show fill data. A wide write command copies the four quad registers onto a 128-bit output, with lane 0 in the least significant bits.

The fill strobe is assumed to arrive only after the shared memory path has spent its own latency, which is about five clocks after the wide read was issued. That latency lives outside this block. Software must not read the window before then.

Top module: `quad_window`

## Requirements
- R1: After reset the window is unmapped: every read returns the RAM word, and `spill_valid` is 0.
- R2: A map command aligns its base down to a multiple of four by ignoring address bits 1:0. The window then covers base+0 to base+3, with lane i at base+i.
- R3: A read of a covered address returns quad lane (addr − base) on `rd_data` one clock after `rd_en`.
- R4: A read of an address outside the window returns the RAM word one clock after `rd_en`.
- R5: A core write to a covered address updates both the matching quad lane and the RAM word at that address.
- R6: A fill strobe loads quad lane i from `fill_data[32i+31:32i]` for all four lanes and leaves every RAM word unchanged.
- R7: If a fill strobe and a core write to a covered lane occur in the same cycle, the quad lane takes the fill data and the RAM word takes the write data.
- R8: Remapping keeps the quad contents. Reads issued after the remap see RAM at the old addresses and the quad lanes at the new ones.
- R9: One clock after `spill_req`, `spill_valid` is high for one cycle and `spill_data` holds the four quad lanes, lane 0 in bits 31:0.
- R10: A read issued in the same cycle as a write or a map command sees the state before that cycle: the old word, and the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Map command strobe |
| map_base | input | 9 | Window base address (bits 1:0 ignored) |
| wr_en | input | 1 | Core write strobe |
| wr_addr | input | 9 | Core write address |
| wr_data | input | 32 | Core write data |
| rd_en | input | 1 | Core read strobe |
| rd_addr | input | 9 | Core read address |
| rd_data | output | 32 | Read result, valid one clock after rd_en |
| fill_valid | input | 1 | Wide read data strobe |
| fill_data | input | 128 | Wide read data, lane 0 in the low bits |
| spill_req | input | 1 | Wide write command |
| spill_valid | output | 1 | Wide write data valid |
| spill_data | output | 128 | Quad lanes, lane 0 in the low bits |

## Verification
The hardest case to reach from the ports is a RAM word hidden under a mapped lane. To see it, the window must be moved away, and both fill data and core writes must have reached that lane beforehand. The stimulus fills, maps, writes through the window, and collides a fill with a write on one lane. It then remaps elsewhere and reads the old addresses, to tell RAM contents apart from quad contents. Same-cycle read/write and read/map pairs are driven on purpose, to pin down the old-state ordering.

// File: rtl/qw_pkg.sv
package qw_pkg;
  localparam int QW_LANES  = 4;
  localparam int QW_LANE_W = $clog2(QW_LANES);

  typedef logic [QW_LANE_W-1:0] qw_lane_t;
endpackage

// File: rtl/qw_regfile.sv
module qw_regfile #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, read-old-data: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qw_window_map.sv
module qw_window_map
  import qw_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_en,
  input  logic [ADDR_W-1:0] map_base,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_hit,
  output qw_lane_t          wr_lane,
  output logic              rd_hit,
  output qw_lane_t          rd_lane
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(QW_LANES - 1);

  logic              mapped;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped <= 1'b0;
      base   <= '0;
    end else if (map_en) begin
      mapped <= 1'b1;
      base   <= map_base & ~ALIGN_MASK;
    end
  end

  assign wr_hit  = mapped && ((wr_addr & ~ALIGN_MASK) == base);
  assign rd_hit  = mapped && ((rd_addr & ~ALIGN_MASK) == base);
  assign wr_lane = qw_lane_t'(wr_addr & ALIGN_MASK);
  assign rd_lane = qw_lane_t'(rd_addr & ALIGN_MASK);

  AST_UNMAPPED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mapped); // R1
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $past(map_en) |-> (base[QW_LANE_W-1:0] == '0 &&
      base[ADDR_W-1:QW_LANE_W] == $past(map_base[ADDR_W-1:QW_LANE_W]))); // R2
endmodule

// File: rtl/qw_quad_bank.sv
module qw_quad_bank
  import qw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fill_valid,
  input  logic [QW_LANES*DATA_W-1:0] fill_data,
  input  logic                       wr_en,
  input  qw_lane_t                   wr_lane,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [QW_LANES*DATA_W-1:0] quad_flat
);
  for (genvar i = 0; i < QW_LANES; i++) begin : g_lane
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (fill_valid)                        // fill beats a core write
        q <= fill_data[i*DATA_W +: DATA_W];
      else if (wr_en && wr_lane == qw_lane_t'(i))
        q <= wr_data;
    end
    assign quad_flat[i*DATA_W +: DATA_W] = q;
  end

  AST_FILL_LOADS_ALL: assert property (@(posedge clk) disable iff (rst)
    $past(fill_valid) |-> quad_flat == $past(fill_data)); // R6
  AST_QUAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(fill_valid) && !$past(wr_en)) |-> $stable(quad_flat)); // R8
endmodule

// File: rtl/quad_window.sv
module quad_window
  import qw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       map_en,
  input  logic [ADDR_W-1:0]          map_base,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       fill_valid,
  input  logic [QW_LANES*DATA_W-1:0] fill_data,
  input  logic                       spill_req,
  output logic                       spill_valid,
  output logic [QW_LANES*DATA_W-1:0] spill_data
);
  localparam int WIDE_W = QW_LANES * DATA_W;

  logic              wr_hit, rd_hit;
  qw_lane_t          wr_lane, rd_lane;
  logic [WIDE_W-1:0] quad_flat;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] quad_rd_q;
  logic              rd_hit_q;

  qw_window_map #(.ADDR_W(ADDR_W)) map_i (
    .clk(clk), .rst(rst), .map_en(map_en), .map_base(map_base),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_hit(wr_hit), .wr_lane(wr_lane), .rd_hit(rd_hit), .rd_lane(rd_lane)
  );

  qw_quad_bank #(.DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_data(fill_data),
    .wr_en(wr_en && wr_hit), .wr_lane(wr_lane), .wr_data(wr_data),
    .quad_flat(quad_flat)
  );

  // RAM always takes core writes; a fill never reaches it.
  qw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(ram_q)
  );

  // Overlay decision and quad lane captured at the same edge as the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit_q  <= 1'b0;
      quad_rd_q <= '0;
    end else if (rd_en) begin
      rd_hit_q  <= rd_hit;
      quad_rd_q <= quad_flat[int'(rd_lane)*DATA_W +: DATA_W];
    end
  end

  assign rd_data = rd_hit_q ? quad_rd_q : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spill_valid <= 1'b0;
      spill_data  <= '0;
    end else begin
      spill_valid <= spill_req;
      if (spill_req) spill_data <= quad_flat;
    end
  end

  AST_SPILL_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    spill_valid |-> spill_data == $past(quad_flat)); // R9
  AST_SPILL_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !spill_valid); // R1
endmodule

// File: tb/quad_window_tb_top.sv
module quad_window_tb_top;
  localparam int AW = 9;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic           map_en, wr_en, rd_en, fill_valid, spill_req;
  logic [AW-1:0]  map_base, wr_addr, rd_addr;
  logic [DW-1:0]  wr_data, rd_data;
  logic [127:0]   fill_data, spill_data;
  logic           spill_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  quad_window #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .map_en(map_en), .map_base(map_base),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .spill_req(spill_req), .spill_valid(spill_valid), .spill_data(spill_data)
  );

  typedef enum logic [2:0] {OP_WR, OP_RD, OP_MAP, OP_FILL} op_e;
  typedef struct packed {
    op_e         op;
    logic [8:0]  addr;
    logic [31:0] data;   // write data, read expectation, or fill seed
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,   9'h010, 32'h0000_00A0, 4'd4},
    '{OP_WR,   9'h011, 32'h0000_00A1, 4'd4},
    '{OP_WR,   9'h012, 32'h0000_00A2, 4'd4},
    '{OP_WR,   9'h013, 32'h0000_00A3, 4'd4},
    '{OP_WR,   9'h020, 32'h0000_00B0, 4'd4},
    '{OP_RD,   9'h011, 32'h0000_00A1, 4'd4},  // R4 unmapped read
    '{OP_FILL, 9'h000, 32'h0000_F000, 4'd6},  // R6 lanes F000..F003
    '{OP_RD,   9'h011, 32'h0000_00A1, 4'd6},  // R6 fill alone maps nothing
    '{OP_MAP,  9'h012, 32'h0,         4'd2},  // R2 aligns to 0x010
    '{OP_RD,   9'h010, 32'h0000_F000, 4'd3},  // R3 lane 0
    '{OP_RD,   9'h013, 32'h0000_F003, 4'd3},  // R3 lane 3
    '{OP_RD,   9'h020, 32'h0000_00B0, 4'd4},  // R4 outside window
    '{OP_WR,   9'h011, 32'h0000_00C1, 4'd5},  // R5 write through window
    '{OP_RD,   9'h011, 32'h0000_00C1, 4'd5},
    '{OP_MAP,  9'h020, 32'h0,         4'd8},  // R8 remap
    '{OP_RD,   9'h010, 32'h0000_00A0, 4'd6},  // R6 RAM untouched by fill
    '{OP_RD,   9'h011, 32'h0000_00C1, 4'd5},  // R5 RAM took the write
    '{OP_RD,   9'h020, 32'h0000_F000, 4'd8},  // R8 quad kept
    '{OP_RD,   9'h021, 32'h0000_00C1, 4'd8}   // R8 lane 1 kept write
  };

  function automatic logic [127:0] seed_fill(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    map_en = 0; wr_en = 0; rd_en = 0; fill_valid = 0; spill_req = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_rd(input string req, input logic [8:0] a, input logic [31:0] exp);
    rd_en = 1; rd_addr = a;
    tick();
    chk(req, 128'(rd_data), 128'(exp));
  endtask

  initial begin
    idle();
    map_base = '0; wr_addr = '0; rd_addr = '0; wr_data = '0; fill_data = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 spill idle", 128'(spill_valid), 128'(0));

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:   begin wr_en = 1; wr_addr = VEC[i].addr; wr_data = VEC[i].data; tick(); end
        OP_MAP:  begin map_en = 1; map_base = VEC[i].addr; tick(); end
        OP_FILL: begin fill_valid = 1; fill_data = seed_fill(VEC[i].data); tick(); end
        default: do_rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
      endcase
    end

    // R9: wide write snapshot, lane 0 low, one-cycle pulse
    spill_req = 1; tick();
    chk("R9 spill valid", 128'(spill_valid), 128'(1));
    chk("R9 spill data", spill_data, {32'h0000_F003, 32'h0000_F002, 32'h0000_00C1, 32'h0000_F000});
    tick();
    chk("R9 spill pulse ends", 128'(spill_valid), 128'(0));

    // R7: fill and covered write collide on lane 2
    map_en = 1; map_base = 9'h040; tick();
    fill_valid = 1; fill_data = seed_fill(32'h0000_E000);
    wr_en = 1; wr_addr = 9'h042; wr_data = 32'h0000_DEAD; tick();
    do_rd("R7 fill wins quad", 9'h042, 32'h0000_E002);
    map_en = 1; map_base = 9'h080; tick();
    do_rd("R7 RAM keeps write", 9'h042, 32'h0000_DEAD);

    // R10: read-during-write sees old RAM word
    rd_en = 1; rd_addr = 9'h020; wr_en = 1; wr_addr = 9'h020; wr_data = 32'h0000_0055; tick();
    chk("R10 RAM old data", 128'(rd_data), 128'h00B0);
    do_rd("R10 RAM new data", 9'h020, 32'h0000_0055);
    // R10: read-during-write on a covered lane sees old quad value
    rd_en = 1; rd_addr = 9'h081; wr_en = 1; wr_addr = 9'h081; wr_data = 32'h0000_0077; tick();
    chk("R10 quad old data", 128'(rd_data), 128'h0000_E001);
    do_rd("R10 quad new data", 9'h081, 32'h0000_0077);
    // R10: map and read in the same cycle use the old mapping
    map_en = 1; map_base = 9'h020; rd_en = 1; rd_addr = 9'h020; tick();
    chk("R10 map not yet active", 128'(rd_data), 128'h0055);
    do_rd("R3 map active", 9'h020, 32'h0000_E000);

    // R1: reset drops the window; RAM contents remain
    rst = 1; spill_req = 1; tick(); rst = 1; tick(); rst = 0;
    chk("R1 spill idle after reset", 128'(spill_valid), 128'(0));
    do_rd("R1 unmapped after reset", 9'h020, 32'h0000_0055);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule